// File: doc/BRIEF.md
# Multi-bank programmable clock divider

This block sits behind a frequency synthesizer and turns one fast source clock into three bank clocks and one feedback clock. The source is the oscillator clock in normal operation. In a bypass test mode it is instead one of two reference clocks, picked by a select pin. Each output divides the source by a ratio taken from static select pins. The ratio comes from a shared pre-divide select combined with that output's own select bits. Every ratio, including /12, /24 and /48, gives an exact 50% duty cycle.

An active-low stop pin parks the three bank clocks low and leaves the feedback clock running, so the loop stays locked. Parking and resuming happen only on whole-period boundaries, so no shortened pulse reaches a bank. An active-low combined reset / output-enable pin clears all divider state and drops the drive-enable flags. The pad ring uses those flags to float the outputs. On release, every divider starts from the same zero count, so the first rising edges of all outputs coincide.

Top module: `clk_bank_divider`

## Requirements
- R1: Banks A and B divide the source by 4 (select 0) or 8 (select 1) when `vco_half` is 0, and by 8 or 16 when `vco_half` is 1.
- R2: Bank C divides the source by 8 (select 0) or 12 (select 1) when `vco_half` is 0, and by 16 or 24 when `vco_half` is 1.
- R3: The feedback ratio is indexed by {`vco_half`, `fb_sel[1]`, `fb_sel[0]`}. Index 0 through 7 gives /8, /16, /12, /24, /16, /32, /24, /48.
- R4: In bypass, `ref_sel` = 0 takes `ref_clk0` as the source and `ref_sel` = 1 takes `ref_clk1`.
- R5: `pll_on` = 1 takes `vco_clk` as the source. `pll_on` = 0 takes the selected reference clock.
- R6: While `rst_oe_n` is low, all four clock outputs are low and all four bits of `drive_en` are 0. Bit order is 0 = A, 1 = B, 2 = C, 3 = feedback.
- R7: While `stop_n` is low, banks A, B and C stay low and the feedback output keeps toggling.
- R8: Stopping or resuming a bank never produces a high pulse shorter than half that bank's period.
- R9: Every output is high for exactly half its period, for every ratio.
- R10: After `rst_oe_n` rises, the first rising edges of all four outputs fall on the same source edge.
- R11: A select change takes effect only at the end of the current output period. Every high and low phase equals half of either the old ratio or the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Oscillator clock, normal source |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| ref_sel | input | 1 | Reference choice, 1 = ref_clk1 |
| pll_on | input | 1 | 1 = oscillator source, 0 = reference bypass |
| vco_half | input | 1 | Shared pre-divide select, doubles all ratios |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| fb_sel | input | 2 | Feedback ratio select |
| stop_n | input | 1 | Active-low park request for banks A to C |
| rst_oe_n | input | 1 | Active-low asynchronous reset and output disable |
| bank_a | output | 1 | Bank A clock |
| bank_b | output | 1 | Bank B clock |
| bank_c | output | 1 | Bank C clock |
| fb_out | output | 1 | Feedback clock |
| drive_en | output | 4 | Per-output drive enables (A, B, C, feedback) |

## Verification
A corrupted counter or latched ratio shows up within one output period at the ports, as a period or high time that differs from the computed ratio. A ratio latched mid-period shows up as a 24 ns phase among 16 ns and 32 ns phases on bank A. A park flag taken at the wrong moment shows up as a clipped high pulse within one bank period of a `stop_n` change. A divider that does not restart from zero shows up as a first rising edge out of step with the others, at the very first source edge after reset release.

// File: rtl/clk_bank_divider.sv
`timescale 1ns/1ps
module clk_bank_divider #(
  parameter int CW = 6
) (
  input  logic       vco_clk,
  input  logic       ref_clk0,
  input  logic       ref_clk1,
  input  logic       ref_sel,
  input  logic       pll_on,
  input  logic       vco_half,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       sel_c,
  input  logic [1:0] fb_sel,
  input  logic       stop_n,
  input  logic       rst_oe_n,
  output logic       bank_a,
  output logic       bank_b,
  output logic       bank_c,
  output logic       fb_out,
  output logic [3:0] drive_en
);
  localparam int NOUT = 4;

  logic src;
  logic run;
  logic [1:0] stop_sync;
  logic [NOUT-1:0][CW-1:0] want, cnt, rat;
  logic [NOUT-1:0] q, hold;

  assign src = pll_on ? vco_clk : (ref_sel ? ref_clk1 : ref_clk0);

  function automatic logic [CW-1:0] scale(input int base, input logic dbl);
    scale = CW'(base) << dbl;
  endfunction

  assign want[0] = scale(sel_a ? 8 : 4, vco_half);
  assign want[1] = scale(sel_b ? 8 : 4, vco_half);
  assign want[2] = scale(sel_c ? 12 : 8, vco_half);
  always_comb
    case (fb_sel)
      2'd0:    want[3] = scale(8, vco_half);
      2'd1:    want[3] = scale(16, vco_half);
      2'd2:    want[3] = scale(12, vco_half);
      default: want[3] = scale(24, vco_half);
    endcase

  always_ff @(posedge src or negedge rst_oe_n)
    if (!rst_oe_n) begin
      stop_sync <= 2'b00;
      run       <= 1'b0;
    end else begin
      stop_sync <= {stop_sync[0], ~stop_n};
      run       <= 1'b1;
    end

  for (genvar i = 0; i < NOUT; i++) begin : g_div
    logic wrap, park_req;
    logic [CW-1:0] nxt;
    assign wrap     = !run || (cnt[i] == rat[i] - 1'b1);
    assign nxt      = cnt[i] + 1'b1;
    assign park_req = (i < NOUT - 1) ? stop_sync[1] : 1'b0;

    always_ff @(posedge src or negedge rst_oe_n)
      if (!rst_oe_n) begin
        cnt[i]  <= '0;
        rat[i]  <= '0;
        q[i]    <= 1'b0;
        hold[i] <= 1'b0;
      end else if (wrap) begin
        cnt[i]  <= '0;
        rat[i]  <= want[i];
        hold[i] <= park_req;
        q[i]    <= !park_req;
      end else begin
        cnt[i]  <= nxt;
        q[i]    <= !hold[i] && (nxt < (rat[i] >> 1));
      end
  end

  assign bank_a   = q[0];
  assign bank_b   = q[1];
  assign bank_c   = q[2];
  assign fb_out   = q[3];
  assign drive_en = {NOUT{run}};
endmodule

// File: rtl/clk_bank_divider_chk.sv
`timescale 1ns/1ps
module clk_bank_divider_chk #(
  parameter int CW = 6
) (
  input logic                src,
  input logic                rst_oe_n,
  input logic                run,
  input logic [3:0]          outs,
  input logic [3:0]          drive_en,
  input logic [3:0][CW-1:0]  cnt,
  input logic [3:0][CW-1:0]  rat
);
  AST_QUIET_IN_RESET: assert property (@(posedge src) !rst_oe_n |-> (drive_en == 4'b0 && outs == 4'b0)); // R6
  AST_A_RISES_AT_START: assert property (@(posedge src) disable iff (!rst_oe_n) $rose(outs[0]) |-> cnt[0] == '0); // R9
  AST_C_RISES_AT_START: assert property (@(posedge src) disable iff (!rst_oe_n) $rose(outs[2]) |-> cnt[2] == '0); // R8
  AST_FB_FALLS_AT_HALF: assert property (@(posedge src) disable iff (!rst_oe_n) $fell(outs[3]) |-> cnt[3] == (rat[3] >> 1)); // R9
  AST_RATIO_HELD: assert property (@(posedge src) disable iff (!rst_oe_n) (run && $past(run) && cnt[0] != '0) |-> $stable(rat[0])); // R11
endmodule

bind clk_bank_divider clk_bank_divider_chk #(.CW(CW)) u_chk (
  .src(src), .rst_oe_n(rst_oe_n), .run(run),
  .outs({fb_out, bank_c, bank_b, bank_a}), .drive_en(drive_en),
  .cnt(cnt), .rat(rat)
);

// File: tb/clk_bank_divider_tb.sv
`timescale 1ns/100ps
module clk_bank_divider_tb;
  logic vco_clk = 0, ref_clk0 = 0, ref_clk1 = 0;
  logic ref_sel = 0, pll_on = 1, vco_half = 0, sel_a = 0, sel_b = 0, sel_c = 0;
  logic [1:0] fb_sel = 0;
  logic stop_n = 1, rst_oe_n = 0;
  logic bank_a, bank_b, bank_c, fb_out;
  logic [3:0] drive_en;
  logic [3:0] outs;
  int total = 0, bad = 0;

  always #4  vco_clk  = ~vco_clk;
  always #10 ref_clk0 = ~ref_clk0;
  always #6  ref_clk1 = ~ref_clk1;

  clk_bank_divider u_dut (
    .vco_clk(vco_clk), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1), .ref_sel(ref_sel),
    .pll_on(pll_on), .vco_half(vco_half), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .fb_sel(fb_sel), .stop_n(stop_n), .rst_oe_n(rst_oe_n),
    .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c), .fb_out(fb_out), .drive_en(drive_en)
  );
  assign outs = {fb_out, bank_c, bank_b, bank_a};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_lvl(input int idx, input logic lvl, output realtime t);
    int n;
    n = 0;
    while (outs[idx] == lvl && n < 4000) begin #1; n++; end
    while (outs[idx] != lvl && n < 4000) begin #1; n++; end
    t = (n < 4000) ? $realtime : -1.0;
  endtask

  task automatic measure(input int idx, output int per, output int hi);
    realtime t1, t2, t3;
    wait_lvl(idx, 1'b1, t1);
    wait_lvl(idx, 1'b0, t2);
    wait_lvl(idx, 1'b1, t3);
    if (t1 < 0 || t2 < 0 || t3 < 0) begin per = -1; hi = -1; end
    else begin per = int'(t3 - t1); hi = int'(t2 - t1); end
  endtask

  task automatic scan(input int idx, input int dur, input int wa, input int wb,
                      input bit with_lo, output int nrise, output int nodd);
    logic prev, cur;
    realtime last;
    bit have;
    int w;
    prev = outs[idx]; last = $realtime; have = 0; nrise = 0; nodd = 0;
    for (int k = 0; k < dur; k++) begin
      #1;
      cur = outs[idx];
      if (cur != prev) begin
        if (have && (prev || with_lo)) begin
          w = int'($realtime - last);
          if (w != wa && w != wb) nodd++;
        end
        if (cur) nrise++;
        have = 1; last = $realtime; prev = cur;
      end
    end
  endtask

  task automatic check_ratio(input int idx, input int r, input string req);
    int per, hi;
    #1000;
    measure(idx, per, hi);
    chk(per == r * 8, req, per, r * 8);
    chk(hi == r * 4, "R9", hi, r * 4);
  endtask

  task automatic t_reset();
    rst_oe_n = 0;
    #50;
    chk(drive_en == 4'b0, "R6", drive_en, 0);
    chk(outs == 4'b0, "R6", outs, 0);
    rst_oe_n = 1;
    #100;
    chk(drive_en == 4'hf, "R6", drive_en, 15);
  endtask

  task automatic t_bank_ab();
    for (int vh = 0; vh < 2; vh++)
      for (int s = 0; s < 2; s++) begin
        vco_half = vh[0]; sel_a = s[0]; sel_b = s[0];
        check_ratio(0, (s ? 8 : 4) << vh, "R1");
        check_ratio(1, (s ? 8 : 4) << vh, "R1");
      end
    vco_half = 0; sel_a = 0; sel_b = 0;
  endtask

  task automatic t_bank_c();
    for (int vh = 0; vh < 2; vh++)
      for (int s = 0; s < 2; s++) begin
        vco_half = vh[0]; sel_c = s[0];
        check_ratio(2, (s ? 12 : 8) << vh, "R2");
      end
    vco_half = 0; sel_c = 0;
  endtask

  task automatic t_fb();
    int tab [8] = '{8, 16, 12, 24, 16, 32, 24, 48};
    for (int c = 0; c < 8; c++) begin
      vco_half = c[2]; fb_sel = c[1:0];
      check_ratio(3, tab[c], "R3");
    end
    vco_half = 0; fb_sel = 0;
  endtask

  task automatic t_bypass();
    int per, hi;
    pll_on = 0; ref_sel = 0;
    #1000; measure(3, per, hi);
    chk(per == 160, "R4", per, 160);
    chk(per != 64, "R5", per, 160);
    ref_sel = 1;
    #1000; measure(3, per, hi);
    chk(per == 96, "R4", per, 96);
    pll_on = 1;
    #1000; measure(3, per, hi);
    chk(per == 64, "R5", per, 64);
    ref_sel = 0;
  endtask

  task automatic t_align();
    int first [4];
    sel_a = 0; sel_b = 1; sel_c = 0; fb_sel = 0;
    rst_oe_n = 0;
    #20;
    rst_oe_n = 1;
    for (int i = 0; i < 4; i++) first[i] = -1;
    for (int k = 0; k < 200; k++) begin
      #1;
      for (int i = 0; i < 4; i++)
        if (first[i] < 0 && outs[i]) first[i] = k;
    end
    for (int i = 1; i < 4; i++)
      chk(first[i] == first[0] && first[0] >= 0, "R10", first[i], first[0]);
    sel_b = 0;
  endtask

  task automatic t_stop();
    int nr, nodd;
    #1000;
    stop_n = 0;
    scan(0, 300, 16, 16, 0, nr, nodd);
    chk(nodd == 0, "R8", nodd, 0);
    scan(0, 300, 16, 16, 0, nr, nodd);
    chk(nr == 0 && bank_a == 0, "R7", nr, 0);
    scan(1, 300, 16, 16, 0, nr, nodd);
    chk(nr == 0 && bank_b == 0, "R7", nr, 0);
    scan(2, 300, 32, 32, 0, nr, nodd);
    chk(nr == 0 && bank_c == 0, "R7", nr, 0);
    scan(3, 300, 32, 32, 1, nr, nodd);
    chk(nr > 0 && nodd == 0, "R7", nr, 4);
    #3;
    stop_n = 1;
    scan(0, 400, 16, 16, 0, nr, nodd);
    chk(nodd == 0 && nr > 0, "R8", nodd, 0);
    stop_n = 0;
    #5;
    scan(2, 400, 32, 32, 0, nr, nodd);
    chk(nodd == 0, "R8", nodd, 0);
    stop_n = 1;
    scan(2, 400, 32, 32, 0, nr, nodd);
    chk(nodd == 0 && nr > 0, "R8", nodd, 0);
  endtask

  task automatic t_sel_change();
    int nr, nodd, per, hi;
    realtime t;
    sel_a = 0;
    #1000;
    wait_lvl(0, 1'b1, t);
    #5;
    sel_a = 1;
    scan(0, 600, 16, 32, 1, nr, nodd);
    chk(nodd == 0, "R11", nodd, 0);
    measure(0, per, hi);
    chk(per == 64, "R11", per, 64);
    sel_a = 0;
    #19;
    sel_a = 1;
    #7;
    sel_a = 0;
    scan(0, 400, 16, 32, 1, nr, nodd);
    chk(nodd == 0, "R11", nodd, 0);
  endtask

  initial begin
    #0.5;
    chk(drive_en == 4'b0 && outs == 4'b0, "R6", outs, 0);
    t_reset();
    t_bank_ab();
    t_bank_c();
    t_fb();
    t_bypass();
    t_align();
    t_stop();
    t_sel_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule